// File: doc/BRIEF.md
# I2C Host Byte Reader

This block is the reading half of an I2C bus host. Software or a DMA engine hands it a 7-bit client address, a direction select and one-cycle START and STOP command pulses. The block drives the open-drain SCL and SDA wires through pull-low enables and samples SDA. It opens the bus, addresses the client and then shifts in bytes one after another. Each finished byte is parked in one holding register, and a ready flag announces it. The same flag serves as the request line of a DMA receive channel.

The block itself decides where a read ends. A STOP request that is pending when a byte's acknowledge slot begins makes that byte the final one: the byte is answered with NACK and followed by a STOP condition. A START request that is pending at that point gives a repeated START instead. No byte can be lost, because the host holds SCL low just before the last bit of a byte while the holding register is still unread. After the register is read the bus runs on, and a command that arrives late is applied one byte later.

The bit rate is set by `half_period`. Each SCL low or high phase lasts that many clock cycles.

Top module: `i2c_host_rx`

## Requirements
- R1: After reset `scl_oe`, `sda_oe`, `rx_ready`, `dma_req`, `addr_nack` and `busy` are all 0. A pull-low enable of 1 drives its wire low, and 0 releases it high.
- R2: A `cmd_start` pulse while idle produces a START condition: SDA falls while SCL is high. The host then sends the 7 address bits MSB first, followed by the direction bit (1 means read, taken from `cmd_read`). SDA never changes while SCL is high inside a bit.
- R3: In the 9th clock of the address byte the host releases SDA and samples it at the end of the high phase. If SDA is high there, `addr_nack` becomes 1, the host sends STOP and goes idle without reading any data. `addr_nack` returns to 0 on the next accepted `cmd_start`.
- R4: Data bits are assembled MSB first. At the end of the 8th high phase the byte is loaded into `rx_data` and `rx_ready` is set. A one-cycle `rx_read` clears `rx_ready` on the next edge. `dma_req` always equals `rx_ready`.
- R5: The host answers every data byte with ACK (SDA low in the 9th clock), except the final byte. The final byte gets NACK (SDA released) and is followed by STOP or a repeated START.
- R6: `cmd_start` and `cmd_stop` in the same cycle while idle read exactly one byte, NACK it and send STOP.
- R7: A `cmd_stop` given after byte n has become ready, and before the acknowledge slot of byte n+1 begins, makes byte n+1 the final byte.
- R8: A `cmd_start` given during a read makes the next byte that reaches its acknowledge slot the final byte. That byte is followed by a repeated START with no STOP in between, and then by a new address phase.
- R9: While `rx_ready` is 1, a data byte whose first 7 bits have been received stalls with SCL held low before its 8th bit, and stays so until `rx_read`.
- R10: Once a stall is released, the final-byte decision is taken about half an SCL period later. A STOP given only after that moment ends the read one byte later than a STOP given before the read.
- R11: With a direction bit of 0 and an acknowledged address, the host sends STOP right after the address byte and receives no data.
- R12: `cmd_stop` while idle is ignored: no bus activity, and `busy` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| half_period | input | DIV_W | Clock cycles per SCL low or high phase |
| cmd_start | input | 1 | One-cycle request for START (when idle) or repeated START (when busy) |
| cmd_stop | input | 1 | One-cycle request to end the read with STOP |
| cmd_addr | input | 7 | Client address, captured when a START request is accepted |
| cmd_read | input | 1 | Direction bit to send, 1 = read |
| rx_read | input | 1 | One-cycle read strobe of the holding register |
| rx_data | output | 8 | Holding register |
| rx_ready | output | 1 | Holding register holds an unread byte |
| dma_req | output | 1 | Receive request to a DMA channel |
| addr_nack | output | 1 | Client did not acknowledge the address |
| busy | output | 1 | A bus transaction is in progress |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| sda_in | input | 1 | Sampled level of the SDA wire |

## Verification
The assertions assume that `half_period` stays constant and non-zero while `busy` is 1, and that commands and `rx_read` are single-cycle pulses. They also assume that the client changes SDA only after it has seen SCL go low, and that SCL is never held low by anyone but the host. The bench follows all of this: it fixes `half_period` at 4 and drives every pulse for exactly one cycle between clock edges. Its client model reacts only to detected SCL falling edges, and it never pulls SCL.

// File: rtl/i2c_hrx_pkg.sv
package i2c_hrx_pkg;

  localparam int unsigned ADDR_W = 7;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_START,
    ST_BIT_LO,
    ST_BIT_HI,
    ST_STOP_LO,
    ST_STOP_HI,
    ST_STOP_END,
    ST_RS_LO,
    ST_RS_HI
  } hrx_state_t;

endpackage

// File: rtl/i2c_hrx_tick.sv
// Phase timer: one tick at the end of every SCL half-period.
module i2c_hrx_tick #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             hold,
  input  logic [DIV_W-1:0] half_period,
  output logic             tick
);

  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic [DIV_W:0]   cnt_inc;
  logic             at_end;

  assign cnt_inc = {1'b0, cnt_q} + {{DIV_W{1'b0}}, 1'b1};
  assign at_end  = cnt_inc >= {1'b0, half_period};
  assign tick    = run && !hold && at_end;

  always_comb begin
    cnt_d = cnt_q;
    if (!run || tick)   cnt_d = '0;
    else if (!at_end)   cnt_d = cnt_inc[DIV_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/i2c_hrx_hold.sv
// Receive shift register and single holding register with ready flag.
module i2c_hrx_hold #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         load,
  input  logic         bit_in,
  input  logic         rd,
  output logic [W-1:0] data,
  output logic         ready
);

  logic [W-2:0] sh_q, sh_d;
  logic [W-1:0] data_d;
  logic         ready_d;

  always_comb begin
    sh_d    = sh_q;
    data_d  = data;
    ready_d = ready;
    if (rd)       ready_d = 1'b0;
    if (shift_en) sh_d    = {sh_q[W-3:0], bit_in};
    if (load) begin
      data_d  = {sh_q, bit_in};
      ready_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      data  <= '0;
      ready <= 1'b0;
    end else begin
      sh_q  <= sh_d;
      data  <= data_d;
      ready <= ready_d;
    end
  end

  assert_read_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !load) |=> !ready);

  assert_load_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (ready && data[0] == $past(bit_in)));

endmodule

// File: rtl/i2c_host_rx.sv
module i2c_host_rx
  import i2c_hrx_pkg::*;
#(
  parameter int unsigned DIV_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  half_period,
  input  logic              cmd_start,
  input  logic              cmd_stop,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              cmd_read,
  input  logic              rx_read,
  output logic [BYTE_W-1:0] rx_data,
  output logic              rx_ready,
  output logic              dma_req,
  output logic              addr_nack,
  output logic              busy,
  output logic              scl_oe,
  output logic              sda_oe,
  input  logic              sda_in
);

  localparam int unsigned CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] ACK_BIT  = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rsync_q;
  logic       rst_core_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_core_n = rsync_q[1];

  hrx_state_t        state_q, state_d;
  logic [CNT_W-1:0]  bit_q, bit_d;
  logic              in_addr_q, in_addr_d;
  logic [BYTE_W-1:0] tx_q, tx_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              dir_q, dir_d;
  logic              final_q, final_d, rs_q, rs_d;
  logic              stop_pend_q, stop_pend_d, rs_pend_q, rs_pend_d;
  logic              nack_q, nack_d;
  logic              tick, stall, shift_en, load;

  assign stall = (state_q == ST_BIT_LO) && !in_addr_q && (bit_q == LAST_BIT) && rx_ready;

  i2c_hrx_tick #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_core_n), .run(state_q != ST_IDLE), .hold(stall),
    .half_period(half_period), .tick(tick)
  );

  i2c_hrx_hold #(.W(BYTE_W)) u_hold (
    .clk(clk), .rst_n(rst_core_n), .shift_en(shift_en), .load(load),
    .bit_in(sda_in), .rd(rx_read), .data(rx_data), .ready(rx_ready)
  );

  // next-state logic
  always_comb begin
    state_d = state_q;  bit_d = bit_q;  in_addr_d = in_addr_q;  tx_d = tx_q;
    addr_d = addr_q;  dir_d = dir_q;  final_d = final_q;  rs_d = rs_q;
    stop_pend_d = stop_pend_q;  rs_pend_d = rs_pend_q;  nack_d = nack_q;
    shift_en = 1'b0;  load = 1'b0;
    case (state_q)
      ST_IDLE: if (cmd_start) begin
        state_d = ST_START;  addr_d = cmd_addr;  dir_d = cmd_read;
        tx_d = {cmd_addr, cmd_read};  nack_d = 1'b0;
        stop_pend_d = cmd_stop;  rs_pend_d = 1'b0;
      end
      ST_START: if (tick) begin
        state_d = ST_BIT_LO;  bit_d = '0;  in_addr_d = 1'b1;
      end
      ST_BIT_LO: if (tick) state_d = ST_BIT_HI;
      ST_BIT_HI: if (tick) begin
        if (bit_q != ACK_BIT) begin
          state_d = ST_BIT_LO;
          bit_d   = bit_q + 1'b1;
          if (in_addr_q) tx_d = {tx_q[BYTE_W-2:0], 1'b0};
          else if (bit_q == LAST_BIT) begin
            load = 1'b1;
            final_d = stop_pend_q || rs_pend_q;
            rs_d = rs_pend_q;
            stop_pend_d = 1'b0;
            rs_pend_d = 1'b0;
          end else shift_en = 1'b1;
        end else if (in_addr_q) begin
          if (sda_in) begin
            nack_d = 1'b1;  state_d = ST_STOP_LO;
          end else if (!dir_q) state_d = ST_STOP_LO;
          else begin
            state_d = ST_BIT_LO;  bit_d = '0;  in_addr_d = 1'b0;
          end
        end else if (final_q) begin
          state_d = rs_q ? ST_RS_LO : ST_STOP_LO;
          final_d = 1'b0;
        end else begin
          state_d = ST_BIT_LO;  bit_d = '0;
        end
      end
      ST_STOP_LO:  if (tick) state_d = ST_STOP_HI;
      ST_STOP_HI:  if (tick) state_d = ST_STOP_END;
      ST_STOP_END: if (tick) begin
        state_d = ST_IDLE;  stop_pend_d = 1'b0;  rs_pend_d = 1'b0;
      end
      ST_RS_LO: if (tick) state_d = ST_RS_HI;
      ST_RS_HI: if (tick) begin
        state_d = ST_START;  tx_d = {addr_q, dir_q};
      end
      default: state_d = ST_IDLE;
    endcase
    // requests while busy apply to the next acknowledge slot
    if (state_q != ST_IDLE && state_q != ST_STOP_END) begin
      if (cmd_stop) stop_pend_d = 1'b1;
      if (cmd_start) begin
        rs_pend_d = 1'b1;  addr_d = cmd_addr;  dir_d = cmd_read;
      end
    end
  end

  // register process
  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      state_q <= ST_IDLE;  bit_q <= '0;  in_addr_q <= 1'b0;  tx_q <= '0;
      addr_q <= '0;  dir_q <= 1'b0;  final_q <= 1'b0;  rs_q <= 1'b0;
      stop_pend_q <= 1'b0;  rs_pend_q <= 1'b0;  nack_q <= 1'b0;
    end else begin
      state_q <= state_d;  bit_q <= bit_d;  in_addr_q <= in_addr_d;  tx_q <= tx_d;
      addr_q <= addr_d;  dir_q <= dir_d;  final_q <= final_d;  rs_q <= rs_d;
      stop_pend_q <= stop_pend_d;  rs_pend_q <= rs_pend_d;  nack_q <= nack_d;
    end
  end

  // line drive
  always_comb begin
    scl_oe = 1'b0;
    sda_oe = 1'b0;
    case (state_q)
      ST_START: sda_oe = 1'b1;
      ST_BIT_LO, ST_BIT_HI: begin
        scl_oe = (state_q == ST_BIT_LO);
        if (bit_q != ACK_BIT) sda_oe = in_addr_q && !tx_q[BYTE_W-1];
        else                  sda_oe = !in_addr_q && !final_q;
      end
      ST_STOP_LO: begin scl_oe = 1'b1; sda_oe = 1'b1; end
      ST_STOP_HI: sda_oe = 1'b1;
      ST_RS_LO:   scl_oe = 1'b1;
      default: ;
    endcase
  end

  assign busy      = (state_q != ST_IDLE);
  assign addr_nack = nack_q;
  assign dma_req   = rx_ready;

  assert_stall_freezes_R9: assert property (@(posedge clk) disable iff (!rst_core_n)
    stall |=> (state_q == ST_BIT_LO && bit_q == $past(bit_q)));

  assert_nack_from_ack_slot_R3: assert property (@(posedge clk) disable iff (!rst_core_n)
    $rose(nack_q) |-> $past(state_q == ST_BIT_HI && in_addr_q && sda_in));

  assert_sda_still_scl_high_R2: assert property (@(posedge clk) disable iff (!rst_core_n)
    (state_q == ST_BIT_HI && $past(state_q == ST_BIT_HI)) |-> $stable(sda_oe));

  assert_final_byte_ends_R5: assert property (@(posedge clk) disable iff (!rst_core_n)
    (tick && state_q == ST_BIT_HI && !in_addr_q && bit_q == ACK_BIT && final_q)
      |=> (state_q == ST_STOP_LO || state_q == ST_RS_LO));

endmodule

// File: tb/i2c_host_rx_test.sv
module i2c_host_rx_test;

  localparam int HALF = 4;
  localparam logic [6:0] CLI = 7'h52;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] half_period = 8'(HALF);
  logic       cmd_start = 1'b0, cmd_stop = 1'b0, cmd_read = 1'b1, rx_read = 1'b0;
  logic [6:0] cmd_addr = CLI;
  logic [7:0] rx_data;
  logic       rx_ready, dma_req, addr_nack, busy, scl_oe, sda_oe;
  logic       scl_line, sda_line;
  logic       cli_low = 1'b0;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  assign scl_line = !scl_oe;
  assign sda_line = !(sda_oe || cli_low);

  i2c_host_rx uut (
    .clk(clk), .rst_n(rst_n), .half_period(half_period),
    .cmd_start(cmd_start), .cmd_stop(cmd_stop), .cmd_addr(cmd_addr), .cmd_read(cmd_read),
    .rx_read(rx_read), .rx_data(rx_data), .rx_ready(rx_ready), .dma_req(dma_req),
    .addr_nack(addr_nack), .busy(busy), .scl_oe(scl_oe), .sda_oe(sda_oe), .sda_in(sda_line)
  );

  function automatic logic [7:0] dat(int i);
    return 8'hC3 + 8'(i * 17);
  endfunction

  // ---------------- client model ----------------
  logic       sp = 1'b1, dp = 1'b1, hack = 1'b0;
  int         bitn = 0, ph = 0, idx = 0;
  logic [7:0] sh = '0, cb, addr_seen = '0;
  int         n_start = 0, n_stop = 0, log_n = 0;
  logic       ack_log [0:63];

  always @(negedge clk) begin
    sp <= scl_line;
    dp <= sda_line;
    if (sp && scl_line && dp && !sda_line) begin
      n_start = n_start + 1;
      ph <= 1; bitn <= 0; idx <= 0; cli_low <= 1'b0;
    end else if (sp && scl_line && !dp && sda_line) begin
      n_stop = n_stop + 1;
      ph <= 0; cli_low <= 1'b0;
    end else if (!sp && scl_line) begin
      if (ph == 1 && bitn < 8) sh <= {sh[6:0], sda_line};
      if (ph == 2 && bitn == 8) begin
        ack_log[log_n] = !sda_line;
        log_n = log_n + 1;
        hack <= !sda_line;
      end
      bitn <= bitn + 1;
    end else if (sp && !scl_line) begin
      if (ph == 1) begin
        if (bitn == 8) begin
          addr_seen = sh;
          cli_low <= (sh[7:1] == CLI);
        end else if (bitn == 9) begin
          if (cli_low && sh[0]) begin
            cb = dat(idx);
            ph <= 2; bitn <= 0; cli_low <= !cb[7];
          end else begin
            ph <= 0; cli_low <= 1'b0;
          end
        end
      end else if (ph == 2) begin
        if (bitn < 8) begin
          cb = dat(idx);
          cli_low <= !cb[7-bitn];
        end else if (bitn == 8) cli_low <= 1'b0;
        else if (hack) begin
          cb = dat(idx + 1);
          idx <= idx + 1; bitn <= 0; cli_low <= !cb[7];
        end else begin
          ph <= 0; cli_low <= 1'b0;
        end
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic pulse_start(input logic [6:0] a, input logic rd, input logic with_stop);
    cmd_addr = a; cmd_read = rd; cmd_start = 1'b1; cmd_stop = with_stop;
    @(negedge clk);
    cmd_start = 1'b0; cmd_stop = 1'b0;
  endtask

  task automatic pulse_stop();
    cmd_stop = 1'b1; @(negedge clk); cmd_stop = 1'b0;
  endtask

  task automatic do_read(input string tag);
    rx_read = 1'b1; @(negedge clk); rx_read = 1'b0;
    chk({tag, " ready cleared by read"}, rx_ready, 0);
  endtask

  task automatic wait_ready(input string tag);
    int n = 0;
    while (!rx_ready && n < 3000) begin @(negedge clk); n++; end
    if (!rx_ready) chk({tag, " ready timeout"}, 0, 1);
  endtask

  task automatic wait_idle(input string tag);
    int n = 0;
    while (busy && n < 5000) begin @(negedge clk); n++; end
    chk({tag, " returns idle"}, busy, 0);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    chk("R1 scl_oe", scl_oe, 0);
    chk("R1 sda_oe", sda_oe, 0);
    chk("R1 rx_ready", rx_ready, 0);
    chk("R1 dma_req", dma_req, 0);
    chk("R1 addr_nack", addr_nack, 0);
    chk("R1 busy", busy, 0);
  endtask

  task automatic t_idle_stop();
    int s0 = n_start, p0 = n_stop;
    int act = 0;
    cmd_stop = 1'b1; @(negedge clk); cmd_stop = 1'b0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (busy || scl_oe || sda_oe) act = 1;
    end
    chk("R12 no activity after idle stop", act, 0);
    chk("R12 no START seen", n_start - s0, 0);
    chk("R12 no STOP seen", n_stop - p0, 0);
  endtask

  task automatic t_single();
    int s0 = n_start, p0 = n_stop, l0 = log_n;
    pulse_start(CLI, 1'b1, 1'b1);
    wait_ready("R6");
    chk("R4 byte data", rx_data, dat(0));
    chk("R4 dma_req follows ready", dma_req, 1);
    chk("R2 address byte on bus", addr_seen, {CLI, 1'b1});
    do_read("R4");
    chk("R4 dma_req drops", dma_req, 0);
    wait_idle("R6");
    chk("R2 START seen", n_start - s0, 1);
    chk("R6 one byte", log_n - l0, 1);
    chk("R5 single byte NACKed", ack_log[l0], 0);
    chk("R6 STOP seen", n_stop - p0, 1);
  endtask

  task automatic t_multi();
    int p0 = n_stop, l0 = log_n;
    pulse_start(CLI, 1'b1, 1'b0);
    for (int i = 0; i < 4; i++) begin
      wait_ready("R7");
      chk("R4 multi data", rx_data, dat(i));
      if (i == 2) pulse_stop();
      do_read("R4");
    end
    wait_idle("R7");
    chk("R7 four bytes", log_n - l0, 4);
    chk("R5 ack byte0", ack_log[l0], 1);
    chk("R5 ack byte1", ack_log[l0+1], 1);
    chk("R5 ack byte2", ack_log[l0+2], 1);
    chk("R5 nack byte3", ack_log[l0+3], 0);
    chk("R7 one STOP", n_stop - p0, 1);
    chk("R7 no extra byte", rx_ready, 0);
  endtask

  task automatic t_addr_nack();
    int p0 = n_stop, l0 = log_n;
    pulse_start(7'h11, 1'b1, 1'b0);
    wait_idle("R3");
    chk("R3 nack flag", addr_nack, 1);
    chk("R3 STOP after nack", n_stop - p0, 1);
    chk("R3 no data", log_n - l0, 0);
    pulse_stop();
    rx_read = 1'b1; @(negedge clk); rx_read = 1'b0;
    repeat (20) @(negedge clk);
    chk("R3 ignored while idle busy", busy, 0);
    chk("R3 ignored while idle ready", rx_ready, 0);
    chk("R3 nack kept", addr_nack, 1);
    pulse_start(CLI, 1'b1, 1'b1);
    chk("R3 nack cleared by start", addr_nack, 0);
    wait_ready("R3");
    do_read("R3");
    wait_idle("R3");
  endtask

  task automatic t_write_dir();
    int p0 = n_stop, l0 = log_n;
    pulse_start(CLI, 1'b0, 1'b0);
    wait_idle("R11");
    chk("R11 address with write bit", addr_seen, {CLI, 1'b0});
    chk("R11 STOP", n_stop - p0, 1);
    chk("R11 no data", log_n - l0, 0);
    chk("R11 ready stays low", rx_ready, 0);
    chk("R11 no nack", addr_nack, 0);
  endtask

  task automatic t_stretch();
    int l0 = log_n;
    pulse_start(CLI, 1'b1, 1'b0);
    wait_ready("R9");
    repeat (300) @(negedge clk);
    chk("R9 SCL held low", scl_oe, 1);
    chk("R9 still busy", busy, 1);
    chk("R9 holding kept", rx_data, dat(0));
    chk("R9 second byte not acked yet", log_n - l0, 1);
    pulse_stop();
    do_read("R9");
    wait_ready("R10");
    chk("R9 byte after stall", rx_data, dat(1));
    do_read("R9");
    wait_idle("R10");
    chk("R10 early stop two bytes", log_n - l0, 2);
    chk("R10 early stop ack0", ack_log[l0], 1);
    chk("R10 early stop nack1", ack_log[l0+1], 0);
  endtask

  task automatic t_late();
    int l0 = log_n;
    pulse_start(CLI, 1'b1, 1'b0);
    wait_ready("R10");
    repeat (200) @(negedge clk);
    do_read("R10");
    repeat (2*HALF + 4) @(negedge clk);
    pulse_stop();
    wait_ready("R10");
    chk("R10 late byte1", rx_data, dat(1));
    do_read("R10");
    wait_ready("R10");
    chk("R10 late byte2", rx_data, dat(2));
    do_read("R10");
    wait_idle("R10");
    chk("R10 late stop three bytes", log_n - l0, 3);
    chk("R10 late ack1", ack_log[l0+1], 1);
    chk("R10 late nack2", ack_log[l0+2], 0);
  endtask

  task automatic t_rstart();
    int s0 = n_start, p0 = n_stop, l0 = log_n;
    pulse_start(CLI, 1'b1, 1'b0);
    wait_ready("R8");
    pulse_start(CLI, 1'b1, 1'b0);
    do_read("R8");
    wait_ready("R8");
    chk("R8 byte1", rx_data, dat(1));
    do_read("R8");
    wait_ready("R8");
    chk("R8 repeated START seen", n_start - s0, 2);
    chk("R8 no STOP between", n_stop - p0, 0);
    chk("R8 nack before restart", ack_log[l0+1], 0);
    chk("R8 new transfer byte0", rx_data, dat(0));
    pulse_stop();
    do_read("R8");
    wait_ready("R8");
    chk("R8 new transfer byte1", rx_data, dat(1));
    do_read("R8");
    wait_idle("R8");
    chk("R8 four bytes", log_n - l0, 4);
    chk("R8 one STOP at end", n_stop - p0, 1);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_idle_stop();
    t_single();
    t_multi();
    t_addr_nack();
    t_write_dir();
    t_stretch();
    t_late();
    t_rstart();
    repeat (10) @(negedge clk);
    finish_run();
  end

endmodule